// File: doc/BRIEF.md
# Interrupt Context Save Sequencer

This block stores the interrupted program's context on the stack when the interrupt controller accepts an interrupt. On the acknowledge strobe it captures the 20-bit program counter, the flag register and the stack pointer it will use. It then writes four bytes to an 8-bit data memory port, one per clock cycle, at descending addresses just below that stack pointer. The saved context is the whole program counter, the 4-bit priority-level field at the top of the flag register and the low flag byte. Bits 11:8 of the flag register are not saved.

The stack pointer comes from the interrupt source. Software interrupts numbered 32 through 63 use the user stack pointer when the user-stack flag is set. Every other source uses the interrupt stack pointer. After the last byte the block pulses done for one cycle. In that same cycle it offers the lowered stack pointer, four below the captured value, together with a write strobe and an indication of which pointer it belongs to. The core applies it to the stack pointer that was chosen. Vector fetch, saving of the register bank and the restore on return are left to other logic.

Top module: `ctx_save_seq`

## Requirements
- R1: While rst_n is low, and in the cycles after its release until an acknowledge is taken, mem_we_o, done_o and sp_we_o are 0.
- R2: An acknowledge accepted at a clock edge produces exactly four byte writes (mem_we_o=1) in the four cycles that follow that edge. No write occurs in any other cycle.
- R3: With S the selected stack pointer at acknowledge, the four writes go to S-1, S-2, S-3 and S-4, in that order.
- R4: The byte written to S-1 holds flag bits 15:12 in bits 7:4 and program counter bits 19:16 in bits 3:0.
- R5: The byte at S-2 is flag bits 7:0, the byte at S-3 is program counter bits 15:8, and the byte at S-4 is program counter bits 7:0. Flag bits 11:8 appear in no byte.
- R6: In the cycle after the fourth write, done_o and sp_we_o are 1 for exactly one cycle, and sp_new_o equals S-4.
- R7: When sw_int_i=1, swnum_i lies in 32..63 and uflag_i=1, S is usp_i and sp_user_o=1 in the done cycle. In every other case S is isp_i and sp_user_o=0.
- R8: The PC, flag, pointer, selection and number inputs are sampled only in the acknowledge cycle. Changing them afterwards leaves the written bytes, addresses and sp_new_o unchanged.
- R9: An acknowledge that arrives while writes are in progress or in the done cycle is ignored and causes no additional writes. An acknowledge in the cycle after done starts a new save.
- R10: Address and pointer arithmetic wraps modulo 2^SP_W. For S=2 the writes go to 1, 0, 0xFFFF and 0xFFFE, and sp_new_o is 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| pc_i | input | 20 | Program counter of the interrupted code |
| flg_i | input | 16 | Flag register |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| uflag_i | input | 1 | User-stack select flag |
| sw_int_i | input | 1 | Acknowledged source is a software interrupt |
| swnum_i | input | 8 | Software interrupt number |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 16 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_user_o | output | 1 | Update targets the user pointer (1) or the interrupt pointer (0) |
| sp_new_o | output | 16 | New stack pointer value |
| done_o | output | 1 | Context save finished |

## Verification
The bench builds the block with its default parameters: a 20-bit program counter, a 16-bit flag register, 16-bit stack pointers, an 8-bit software interrupt number, and a user-stack window of 32 through 63. With 16-bit pointers, a stack pointer of 2 makes the writes wrap past zero. The 8-bit number reaches 31 and 64, the values on either side of the window edges, as well as 32 and 63. Flag patterns with distinct nibbles show that bits 11:8 are dropped and that the two high nibbles are packed in the right order.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DONE = 2'd2
  } ctx_state_e;

  localparam int unsigned CTX_BYTES = 4;
  localparam int unsigned BYTE_W    = 8;

endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned SWN_W  = 8,
  parameter int unsigned USR_LO = 32,
  parameter int unsigned USR_HI = 63
) (
  input  logic [SP_W-1:0]  isp_i,
  input  logic [SP_W-1:0]  usp_i,
  input  logic             uflag_i,
  input  logic             sw_int_i,
  input  logic [SWN_W-1:0] swnum_i,
  output logic             use_usr_o,
  output logic [SP_W-1:0]  sp_base_o
);

  localparam logic [SWN_W-1:0] LO_CODE = SWN_W'(USR_LO);
  localparam logic [SWN_W-1:0] HI_CODE = SWN_W'(USR_HI);

  logic in_window;

  always_comb begin
    in_window = (swnum_i >= LO_CODE) && (swnum_i <= HI_CODE);
    use_usr_o = sw_int_i && in_window && uflag_i;
    sp_base_o = use_usr_o ? usp_i : isp_i;
  end

endmodule

// File: rtl/ctx_byte_pack.sv
module ctx_byte_pack
  import ctx_save_pkg::*;
#(
  parameter int unsigned PC_W  = 20,
  parameter int unsigned FLG_W = 16,
  parameter int unsigned SP_W  = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [SP_W-1:0]   sp_base_i,
  output logic [BYTE_W-1:0] byte_o [CTX_BYTES],
  output logic [SP_W-1:0]   addr_o [CTX_BYTES]
);

  localparam int unsigned PCH_W = PC_W - 2 * BYTE_W;
  localparam int unsigned IPL_W = BYTE_W - PCH_W;

  // Saved bytes, listed in write order
  always_comb begin
    byte_o[0] = {flg_i[FLG_W-1 -: IPL_W], pc_i[PC_W-1 -: PCH_W]};
    byte_o[1] = flg_i[BYTE_W-1:0];
    byte_o[2] = pc_i[2*BYTE_W-1:BYTE_W];
    byte_o[3] = pc_i[BYTE_W-1:0];
  end

  // Slot k sits k+1 bytes below the captured pointer
  for (genvar k = 0; k < CTX_BYTES; k++) begin : g_addr
    assign addr_o[k] = sp_base_i - SP_W'(k + 1);
  end

endmodule

// File: rtl/ctx_save_fsm.sv
module ctx_save_fsm
  import ctx_save_pkg::*;
#(
  parameter int unsigned NBYTES = CTX_BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ack_i,
  output ctx_state_e                  state_o,
  output logic [$clog2(NBYTES)-1:0]   idx_o,
  output logic                        load_o
);

  localparam int unsigned IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  ctx_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ack_i) begin
          state_d = ST_PUSH;
          idx_d   = '0;
          load_o  = 1'b1;
        end
      end
      ST_PUSH: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_en = (state_q != ST_IDLE) || ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  AST_BUSY_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH && ack_i) |=> (state_q != ST_IDLE)); // R9

  AST_BURST_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH && $past(state_q) == ST_IDLE) |-> (idx_q == '0)); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> ($past(state_q) == ST_PUSH && $past(idx_q) == LAST_IDX)); // R6

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
  import ctx_save_pkg::*;
#(
  parameter int unsigned PC_W   = 20,
  parameter int unsigned FLG_W  = 16,
  parameter int unsigned SP_W   = 16,
  parameter int unsigned SWN_W  = 8,
  parameter int unsigned USR_LO = 32,
  parameter int unsigned USR_HI = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [SP_W-1:0]   isp_i,
  input  logic [SP_W-1:0]   usp_i,
  input  logic              uflag_i,
  input  logic              sw_int_i,
  input  logic [SWN_W-1:0]  swnum_i,
  output logic              mem_we_o,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              sp_we_o,
  output logic              sp_user_o,
  output logic [SP_W-1:0]   sp_new_o,
  output logic              done_o
);

  localparam int unsigned IDX_W = $clog2(CTX_BYTES);

  ctx_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              load_en;
  logic              sel_usr;
  logic [SP_W-1:0]   sel_base;

  logic [PC_W-1:0]   pc_q;
  logic [FLG_W-1:0]  flg_q;
  logic [SP_W-1:0]   base_q;
  logic              usr_q;

  logic [BYTE_W-1:0] slot_byte [CTX_BYTES];
  logic [SP_W-1:0]   slot_addr [CTX_BYTES];

  ctx_save_fsm #(.NBYTES(CTX_BYTES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_i   (ack_i),
    .state_o (state),
    .idx_o   (idx),
    .load_o  (load_en)
  );

  ctx_sp_select #(
    .SP_W   (SP_W),
    .SWN_W  (SWN_W),
    .USR_LO (USR_LO),
    .USR_HI (USR_HI)
  ) u_sel (
    .isp_i     (isp_i),
    .usp_i     (usp_i),
    .uflag_i   (uflag_i),
    .sw_int_i  (sw_int_i),
    .swnum_i   (swnum_i),
    .use_usr_o (sel_usr),
    .sp_base_o (sel_base)
  );

  // Context capture, enabled only on an accepted acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      flg_q  <= '0;
      base_q <= '0;
      usr_q  <= 1'b0;
    end else if (load_en) begin
      pc_q   <= pc_i;
      flg_q  <= flg_i;
      base_q <= sel_base;
      usr_q  <= sel_usr;
    end
  end

  ctx_byte_pack #(
    .PC_W  (PC_W),
    .FLG_W (FLG_W),
    .SP_W  (SP_W)
  ) u_pack (
    .pc_i      (pc_q),
    .flg_i     (flg_q),
    .sp_base_i (base_q),
    .byte_o    (slot_byte),
    .addr_o    (slot_addr)
  );

  always_comb begin
    mem_we_o    = (state == ST_PUSH);
    mem_addr_o  = slot_addr[idx];
    mem_wdata_o = slot_byte[idx];
    done_o      = (state == ST_DONE);
    sp_we_o     = done_o;
    sp_user_o   = usr_q;
    sp_new_o    = base_q - SP_W'(CTX_BYTES);
  end

  AST_ADDR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - SP_W'(1))); // R3

  AST_DONE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_we_o)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_SP_MATCHES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_new_o == $past(mem_addr_o))); // R6

  AST_WRITE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && done_o)); // R2

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> $stable(sp_new_o)); // R8

endmodule

// File: tb/ctx_save_seq_bench.sv
module ctx_save_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_i = 1'b0;
  logic [19:0] pc_i = '0;
  logic [15:0] flg_i = '0;
  logic [15:0] isp_i = '0;
  logic [15:0] usp_i = '0;
  logic        uflag_i = 1'b0;
  logic        sw_int_i = 1'b0;
  logic [7:0]  swnum_i = '0;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        sp_we_o;
  logic        sp_user_o;
  logic [15:0] sp_new_o;
  logic        done_o;

  ctx_save_seq u_ctx_save_seq (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .pc_i(pc_i), .flg_i(flg_i),
    .isp_i(isp_i), .usp_i(usp_i), .uflag_i(uflag_i), .sw_int_i(sw_int_i),
    .swnum_i(swnum_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .sp_we_o(sp_we_o), .sp_user_o(sp_user_o),
    .sp_new_o(sp_new_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          cyc;
    bit          is_done;
    logic [15:0] addr;
    logic [7:0]  data;
    bit          usr;
    string       rq;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: one acknowledge, expected items pushed to the scoreboard
  task automatic push_ctx(input logic [19:0] pc, input logic [15:0] flg,
                          input logic [15:0] isp, input logic [15:0] usp,
                          input logic uf, input logic sw, input logic [7:0] num,
                          input string rq, input bit garble, input bit poke);
    logic        usr;
    logic [15:0] s;
    logic [7:0]  bytes [4];
    exp_t        it;
    usr = sw && (num >= 8'd32) && (num <= 8'd63) && uf;
    s   = usr ? usp : isp;
    bytes[0] = {flg[15:12], pc[19:16]};
    bytes[1] = flg[7:0];
    bytes[2] = pc[15:8];
    bytes[3] = pc[7:0];
    pc_i = pc; flg_i = flg; isp_i = isp; usp_i = usp;
    uflag_i = uf; sw_int_i = sw; swnum_i = num;
    ack_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      it.cyc = cyc + 1 + i;
      it.is_done = 1'b0;
      it.addr = s - 16'(i + 1);
      it.data = bytes[i];
      it.usr = usr;
      it.rq = garble ? "R8" : ((i == 0) ? "R4" : "R5");
      exp_q.push_back(it);
    end
    it.cyc = cyc + 5;
    it.is_done = 1'b1;
    it.addr = s - 16'd4;
    it.data = '0;
    it.usr = usr;
    it.rq = rq;
    exp_q.push_back(it);
    for (int j = 1; j <= 6; j++) begin
      @(posedge clk); #1;
      ack_i = poke && (j == 1 || j == 5);
      if (garble && j == 1) begin
        pc_i = ~pc; flg_i = ~flg; isp_i = isp ^ 16'h5A5A; usp_i = usp ^ 16'hA5A5;
        uflag_i = ~uf; sw_int_i = ~sw; swnum_i = num ^ 8'h21;
      end
    end
    ack_i = 1'b0;
  endtask

  // Monitor: compares design output against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t it;
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        it = exp_q.pop_front();
        chk(1'b0, "R2", it.is_done ? "missing done" : "missing write", 0, 1);
      end
      if (mem_we_o && done_o) chk(1'b0, "R2", "write and done together", 1, 0);
      if (mem_we_o) begin
        if (exp_q.size() == 0 || exp_q[0].is_done) begin
          chk(1'b0, "R9", "unexpected write at addr", mem_addr_o, 0);
        end else begin
          it = exp_q.pop_front();
          chk(it.cyc == cyc, "R2", "write cycle", cyc, it.cyc);
          chk(mem_addr_o == it.addr, "R3", "write addr", mem_addr_o, it.addr);
          chk(mem_wdata_o == it.data, it.rq, "write data", mem_wdata_o, it.data);
        end
      end else if (done_o) begin
        if (exp_q.size() == 0 || !exp_q[0].is_done) begin
          chk(1'b0, "R6", "unexpected done", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(it.cyc == cyc, "R6", "done cycle", cyc, it.cyc);
          chk(sp_we_o == 1'b1, "R6", "sp_we in done", sp_we_o, 1);
          chk(sp_new_o == it.addr, it.rq, "sp_new", sp_new_o, it.addr);
          chk(sp_user_o == it.usr, it.rq, "sp_user", sp_user_o, it.usr);
        end
      end else if (sp_we_o) begin
        chk(1'b0, "R6", "sp_we without done", 1, 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    // R1: quiet during and after reset
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_we_o && !done_o && !sp_we_o, "R1", "outputs in reset",
        {mem_we_o, done_o, sp_we_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!mem_we_o && !done_o && !sp_we_o, "R1", "outputs after reset",
        {mem_we_o, done_o, sp_we_o}, 0);

    // R6 / R7: hardware source uses interrupt pointer even with uflag set
    push_ctx(20'hABCDE, 16'h9F31, 16'h1000, 16'h2000, 1'b1, 1'b0, 8'd40, "R7", 1'b0, 1'b0);
    // R7: software window edges
    push_ctx(20'h12345, 16'h5A6B, 16'h1100, 16'h2200, 1'b1, 1'b1, 8'd32, "R7", 1'b0, 1'b0);
    push_ctx(20'hF0F0F, 16'hC3E7, 16'h1200, 16'h2300, 1'b1, 1'b1, 8'd63, "R7", 1'b0, 1'b0);
    push_ctx(20'h00FF0, 16'h7700, 16'h1300, 16'h2400, 1'b1, 1'b1, 8'd64, "R7", 1'b0, 1'b0);
    push_ctx(20'h80001, 16'h0EFF, 16'h1400, 16'h2500, 1'b1, 1'b1, 8'd31, "R7", 1'b0, 1'b0);
    push_ctx(20'h3C3C3, 16'hF000, 16'h1500, 16'h2600, 1'b0, 1'b1, 8'd48, "R7", 1'b0, 1'b0);
    // R8: inputs scrambled after acknowledge
    push_ctx(20'h6789A, 16'hB2D4, 16'h3000, 16'h4000, 1'b1, 1'b1, 8'd33, "R8", 1'b1, 1'b0);
    // R9: acknowledges during writes and done are ignored
    push_ctx(20'h13579, 16'h8642, 16'h5000, 16'h6000, 1'b0, 1'b0, 8'd0, "R9", 1'b0, 1'b1);
    // R9: back-to-back save accepted right after done
    push_ctx(20'h24680, 16'h1357, 16'h5100, 16'h6100, 1'b0, 1'b0, 8'd0, "R9", 1'b0, 1'b0);
    // R10: wrap below zero
    push_ctx(20'hFFFFF, 16'hFFFF, 16'h0002, 16'h7000, 1'b0, 1'b0, 8'd5, "R10", 1'b0, 1'b0);
    push_ctx(20'h00000, 16'h0000, 16'h9000, 16'h0001, 1'b1, 1'b1, 8'd50, "R10", 1'b0, 1'b0);

    repeat (10) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R2", "pending expected items", exp_q.size(), 0);
    finish_run();
  end

endmodule